// File: doc/BRIEF.md
# Valid-ready memory port to AXI4-Lite master bridge

This block sits between a small processor's single-outstanding memory request port and an AXI4-Lite interconnect. The requester raises a valid strobe and holds address, write data, byte strobe and an instruction-fetch flag steady until the bridge answers with a one-cycle ready. The bridge turns each such request into exactly one AXI4-Lite transaction: a read when the byte strobe is all zero, and a write on the address and write-data channels otherwise.

Channel valids are formed combinationally from the held request, so an AXI slave that is always ready sees its handshake in the same cycle the request appears. Ready goes back to the requester in the cycle of the matching response handshake, with read data passed straight through from the read-data channel. One cycle after each completion the bridge does not look at the request, so a request that the requester has not yet dropped is not issued a second time. The fetch flag becomes the instruction bit of the AXI protection field.

Top module: `membus_axil_bridge`

## Requirements
- R1: While `rst_n` is low, `m_awvalid`, `m_wvalid`, `m_arvalid` and `req_ready` are all low, whatever the request inputs are.
- R2: A request whose `req_strb` is all zero is a read: only `m_arvalid` is raised, with `m_araddr` equal to `req_addr`; `req_wdata` has no effect on any output.
- R3: A request with a nonzero `req_strb` is a write: `m_awvalid` and `m_wvalid` rise in the same cycle, carrying `req_addr`, `req_wdata` and `req_strb` unchanged.
- R4: `m_awvalid` and `m_wvalid` each stay high and stable until their own handshake, then fall in the next cycle and stay low for the rest of that transfer, independently of the other channel.
- R5: `m_arvalid` stays high and stable until `m_arready` is seen, then falls in the next cycle and stays low for the rest of that transfer.
- R6: `m_bready` is always high; a write completes with `req_ready` high in exactly the cycle in which `m_bvalid` is high.
- R7: A read completes with `req_ready` high in exactly the cycle in which `m_rvalid` is high (`m_rready` is always high), and in that cycle `req_rdata` equals `m_rdata`.
- R8: `m_awprot` and `m_arprot` are 3'b100 when `req_fetch` is high and 3'b000 when it is low (bit 2 = instruction access, bits 1:0 zero).
- R9: In the cycle after `req_ready` is high, no AXI valid and no `req_ready` are raised even if `req_valid` is still high; a request present in the following cycle is issued normally.
- R10: A response on the channel that does not match the outstanding request kind (`m_rvalid` during a write, `m_bvalid` during a read) does not raise `req_ready` and does not end the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_fetch | input | 1 | Request is an instruction fetch |
| req_addr | input | ADDR_W | Request byte address |
| req_wdata | input | DATA_W | Write data |
| req_strb | input | DATA_W/8 | Byte write enables; all zero means read |
| req_ready | output | 1 | Transfer complete (one cycle) |
| req_rdata | output | DATA_W | Read data, meaningful while req_ready is high |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_awaddr | output | ADDR_W | Write address |
| m_awprot | output | 3 | Write protection attributes |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_wdata | output | DATA_W | Write data |
| m_wstrb | output | DATA_W/8 | Write byte strobes |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |
| m_arvalid | output | 1 | Read address valid |
| m_arready | input | 1 | Read address ready |
| m_araddr | output | ADDR_W | Read address |
| m_arprot | output | 3 | Read protection attributes |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data ready |
| m_rdata | input | DATA_W | Read data |

## Verification
The bound checker watches on every cycle that reset keeps all valids and ready low, that a read never drives write channels, that the address and data valids rise together and hold until their own handshake and then drop, that protection bits follow the fetch flag, that ready only accompanies the matching response, and that the cycle after a completion is silent. Whether each request produces exactly one handshake per channel, that the slave captures the right address, data, strobe and protection, that read data reaches the requester intact, and that a held request is re-issued only after the quiet cycle can only be shown by the bench's transfers against its modelled slave with varying ready densities, response delays and injected mismatched responses.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

   // channel slots for the handshake trackers
   localparam int CH_AW  = 0;
   localparam int CH_W   = 1;
   localparam int CH_AR  = 2;
   localparam int NUM_CH = 3;

   localparam int PROT_W     = 3;
   localparam int PROT_INSTR = 2;   // bit that marks an instruction access

   function automatic logic [PROT_W-1:0] prot_for(input logic is_fetch);
      logic [PROT_W-1:0] p;
      p             = '0;
      p[PROT_INSTR] = is_fetch;
      return p;
   endfunction

endpackage

// File: rtl/mbx_classify.sv
// Decides whether the held request is live this cycle and which kind it is.
module mbx_classify #(
   parameter int STRB_W = 4
) (
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              quiet,
   input  logic [STRB_W-1:0] req_strb,
   output logic              live_wr,
   output logic              live_rd
);

   logic live;
   logic any_byte;

   always_comb begin
      live     = rst_n && req_valid && !quiet;
      any_byte = |req_strb;
      live_wr  = live && any_byte;
      live_rd  = live && !any_byte;
   end

endmodule

// File: rtl/mbx_chan_track.sv
// One AXI request channel: valid follows the live request until its own
// handshake, then stays low until the whole transfer is retired.
module mbx_chan_track (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic accept,
   input  logic retire,
   output logic valid
);

   logic taken_q;

   always_comb valid = arm && !taken_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         taken_q <= 1'b0;
      else if (retire)
         taken_q <= 1'b0;
      else if (valid && accept)
         taken_q <= 1'b1;
   end

endmodule

// File: rtl/mbx_resp_join.sv
// Returns completion to the requester from the response channel that
// matches the outstanding request kind.
module mbx_resp_join #(
   parameter int DATA_W = 32
) (
   input  logic              live_wr,
   input  logic              live_rd,
   input  logic              bvalid,
   input  logic              rvalid,
   input  logic [DATA_W-1:0] rdata,
   output logic              done,
   output logic [DATA_W-1:0] done_data
);

   always_comb begin
      done      = (live_wr && bvalid) || (live_rd && rvalid);
      done_data = rdata;
   end

endmodule

// File: rtl/membus_axil_bridge.sv
module membus_axil_bridge #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   input  logic                  req_fetch,
   input  logic [ADDR_W-1:0]     req_addr,
   input  logic [DATA_W-1:0]     req_wdata,
   input  logic [DATA_W/8-1:0]   req_strb,
   output logic                  req_ready,
   output logic [DATA_W-1:0]     req_rdata,
   output logic                  m_awvalid,
   input  logic                  m_awready,
   output logic [ADDR_W-1:0]     m_awaddr,
   output logic [2:0]            m_awprot,
   output logic                  m_wvalid,
   input  logic                  m_wready,
   output logic [DATA_W-1:0]     m_wdata,
   output logic [DATA_W/8-1:0]   m_wstrb,
   input  logic                  m_bvalid,
   output logic                  m_bready,
   output logic                  m_arvalid,
   input  logic                  m_arready,
   output logic [ADDR_W-1:0]     m_araddr,
   output logic [2:0]            m_arprot,
   input  logic                  m_rvalid,
   output logic                  m_rready,
   input  logic [DATA_W-1:0]     m_rdata
);

   import mbx_pkg::*;

   localparam int STRB_W = DATA_W / 8;

   // elaboration-time parameter checks
   if ((DATA_W != 32) && (DATA_W != 64)) begin : g_bad_data_w
      $error("membus_axil_bridge: DATA_W must be 32 or 64");
   end
   if ((ADDR_W < 2) || (ADDR_W > 64)) begin : g_bad_addr_w
      $error("membus_axil_bridge: ADDR_W must lie in 2..64");
   end
   if (STRB_W * 8 != DATA_W) begin : g_bad_strb_w
      $error("membus_axil_bridge: DATA_W must be a whole number of bytes");
   end

   logic              quiet_q;
   logic              live_wr;
   logic              live_rd;
   logic              done;
   logic [NUM_CH-1:0] arm_v;
   logic [NUM_CH-1:0] acc_v;
   logic [NUM_CH-1:0] vld_v;

   mbx_classify #(.STRB_W(STRB_W)) u_cls (
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .quiet     (quiet_q),
      .req_strb  (req_strb),
      .live_wr   (live_wr),
      .live_rd   (live_rd)
   );

   always_comb begin
      arm_v        = '0;
      acc_v        = '0;
      arm_v[CH_AW] = live_wr;
      arm_v[CH_W]  = live_wr;
      arm_v[CH_AR] = live_rd;
      acc_v[CH_AW] = m_awready;
      acc_v[CH_W]  = m_wready;
      acc_v[CH_AR] = m_arready;
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      mbx_chan_track u_trk (
         .clk    (clk),
         .rst_n  (rst_n),
         .arm    (arm_v[c]),
         .accept (acc_v[c]),
         .retire (done),
         .valid  (vld_v[c])
      );
   end

   mbx_resp_join #(.DATA_W(DATA_W)) u_resp (
      .live_wr   (live_wr),
      .live_rd   (live_rd),
      .bvalid    (m_bvalid),
      .rvalid    (m_rvalid),
      .rdata     (m_rdata),
      .done      (done),
      .done_data (req_rdata)
   );

   // one quiet cycle after each completion
   always_ff @(posedge clk) begin
      if (!rst_n)
         quiet_q <= 1'b0;
      else
         quiet_q <= done;
   end

   always_comb begin
      req_ready = done;
      m_awvalid = vld_v[CH_AW];
      m_wvalid  = vld_v[CH_W];
      m_arvalid = vld_v[CH_AR];
      m_awaddr  = req_addr;
      m_araddr  = req_addr;
      m_wdata   = req_wdata;
      m_wstrb   = req_strb;
      m_awprot  = prot_for(req_fetch);
      m_arprot  = prot_for(req_fetch);
      m_bready  = 1'b1;
      m_rready  = 1'b1;
   end

endmodule

// File: rtl/mbx_bridge_chk.sv
module mbx_bridge_chk #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input logic                clk,
   input logic                rst_n,
   input logic                req_fetch,
   input logic [DATA_W/8-1:0] req_strb,
   input logic                req_ready,
   input logic [DATA_W-1:0]   req_rdata,
   input logic                m_awvalid,
   input logic                m_awready,
   input logic [ADDR_W-1:0]   m_awaddr,
   input logic [2:0]          m_awprot,
   input logic                m_wvalid,
   input logic                m_wready,
   input logic [DATA_W-1:0]   m_wdata,
   input logic                m_bvalid,
   input logic                m_bready,
   input logic                m_arvalid,
   input logic                m_arready,
   input logic [ADDR_W-1:0]   m_araddr,
   input logic [2:0]          m_arprot,
   input logic                m_rvalid,
   input logic                m_rready,
   input logic [DATA_W-1:0]   m_rdata
);

   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |-> !m_awvalid && !m_wvalid && !m_arvalid && !req_ready);

   assert_read_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
      m_arvalid |-> (req_strb == '0) && !m_awvalid && !m_wvalid);

   assert_write_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(m_awvalid) |-> m_wvalid);

   assert_aw_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      m_awvalid && !m_awready |=> m_awvalid && $stable(m_awaddr));

   assert_w_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      m_wvalid && !m_wready |=> m_wvalid && $stable(m_wdata));

   assert_aw_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
      m_awvalid && m_awready |=> !m_awvalid);

   assert_w_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
      m_wvalid && m_wready |=> !m_wvalid);

   assert_ar_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      m_arvalid && !m_arready |=> m_arvalid && $stable(m_araddr));

   assert_ar_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      m_arvalid && m_arready |=> !m_arvalid);

   assert_resp_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
      m_bready && m_rready);

   assert_write_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready && (req_strb != '0) |-> m_bvalid);

   assert_read_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready && (req_strb == '0) |-> m_rvalid && (req_rdata == m_rdata));

   assert_awprot_R8: assert property (@(posedge clk) disable iff (!rst_n)
      m_awvalid |-> m_awprot == {req_fetch, 2'b00});

   assert_arprot_R8: assert property (@(posedge clk) disable iff (!rst_n)
      m_arvalid |-> m_arprot == {req_fetch, 2'b00});

   assert_quiet_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |=> !req_ready && !m_awvalid && !m_wvalid && !m_arvalid);

   assert_wrong_resp_R10: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !((req_strb != '0) && m_rvalid && !m_bvalid)
                 && !((req_strb == '0) && m_bvalid && !m_rvalid));

endmodule

bind membus_axil_bridge mbx_bridge_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_fetch (req_fetch),
   .req_strb  (req_strb),
   .req_ready (req_ready),
   .req_rdata (req_rdata),
   .m_awvalid (m_awvalid),
   .m_awready (m_awready),
   .m_awaddr  (m_awaddr),
   .m_awprot  (m_awprot),
   .m_wvalid  (m_wvalid),
   .m_wready  (m_wready),
   .m_wdata   (m_wdata),
   .m_bvalid  (m_bvalid),
   .m_bready  (m_bready),
   .m_arvalid (m_arvalid),
   .m_arready (m_arready),
   .m_araddr  (m_araddr),
   .m_arprot  (m_arprot),
   .m_rvalid  (m_rvalid),
   .m_rready  (m_rready),
   .m_rdata   (m_rdata)
);

// File: tb/sim_membus_axil_bridge.sv
`timescale 1ns/1ps
module sim_membus_axil_bridge;

   localparam int    AW = 32;
   localparam int    DW = 32;
   localparam logic [31:0] RKEY = 32'h5A5A_C3C3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;   // 50 MHz

   logic          req_valid = 0, req_fetch = 0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic [3:0]    req_strb = '0;
   logic          req_ready;
   logic [DW-1:0] req_rdata;
   logic          m_awvalid, m_wvalid, m_arvalid, m_bready, m_rready;
   logic          m_awready = 0, m_wready = 0, m_arready = 0;
   logic          m_bvalid = 0, m_rvalid = 0;
   logic [AW-1:0] m_awaddr, m_araddr;
   logic [2:0]    m_awprot, m_arprot;
   logic [DW-1:0] m_wdata;
   logic [3:0]    m_wstrb;
   logic [DW-1:0] m_rdata = 32'hBAD0_BAD0;

   membus_axil_bridge #(.ADDR_W(AW), .DATA_W(DW)) u0 (.*);

   int nchk = 0, nfail = 0;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- reference model, compared every cycle ----------------
   bit m_quiet = 0, m_awtk = 0, m_wtk = 0, m_artk = 0;
   bit n_quiet, n_awtk, n_wtk, n_artk;

   always @(negedge clk) begin
      bit live, wr, e_aw, e_w, e_ar, e_rdy;
      live  = rst_n && req_valid && !m_quiet;
      wr    = (req_strb != 4'h0);
      e_aw  = live && wr && !m_awtk;
      e_w   = live && wr && !m_wtk;
      e_ar  = live && !wr && !m_artk;
      e_rdy = live && ((wr && m_bvalid) || (!wr && m_rvalid));
      chk("R1 R3 R4 R9 awvalid", 64'(m_awvalid), 64'(e_aw));
      chk("R1 R3 R4 R9 wvalid", 64'(m_wvalid), 64'(e_w));
      chk("R1 R2 R5 R9 arvalid", 64'(m_arvalid), 64'(e_ar));
      chk("R1 R6 R7 R10 req_ready", 64'(req_ready), 64'(e_rdy));
      chk("R6 R7 bready/rready", 64'({m_bready, m_rready}), 64'(2'b11));
      if (e_aw) begin
         chk("R3 awaddr", 64'(m_awaddr), 64'(req_addr));
         chk("R8 awprot", 64'(m_awprot), 64'({req_fetch, 2'b00}));
      end
      if (e_w) begin
         chk("R3 wdata", 64'(m_wdata), 64'(req_wdata));
         chk("R3 wstrb", 64'(m_wstrb), 64'(req_strb));
      end
      if (e_ar) begin
         chk("R2 araddr", 64'(m_araddr), 64'(req_addr));
         chk("R8 arprot", 64'(m_arprot), 64'({req_fetch, 2'b00}));
      end
      if (e_rdy && !wr) chk("R7 rdata", 64'(req_rdata), 64'(m_rdata));
      if (!rst_n) begin
         n_quiet = 0; n_awtk = 0; n_wtk = 0; n_artk = 0;
      end else begin
         n_quiet = e_rdy;
         n_awtk  = e_rdy ? 1'b0 : (m_awtk || (e_aw && m_awready));
         n_wtk   = e_rdy ? 1'b0 : (m_wtk  || (e_w  && m_wready));
         n_artk  = e_rdy ? 1'b0 : (m_artk || (e_ar && m_arready));
      end
   end

   always @(posedge clk) begin
      m_quiet <= n_quiet; m_awtk <= n_awtk; m_wtk <= n_wtk; m_artk <= n_artk;
   end

   // ---------------- AXI slave model ----------------
   int aw_pct = 100, w_pct = 100, ar_pct = 100, resp_lat = 0;
   bit aw_seen = 0, w_seen = 0, ar_seen = 0, spur_b = 0, spur_r = 0;
   int b_cnt = 0, r_cnt = 0, n_aw = 0, n_w = 0, n_ar = 0;
   logic [AW-1:0] cap_awaddr, cap_araddr;
   logic [DW-1:0] cap_wdata;
   logic [3:0]    cap_wstrb;
   logic [2:0]    cap_awprot, cap_arprot;

   always @(negedge clk) begin
      if (rst_n && m_awvalid && m_awready) begin
         aw_seen = 1; n_aw++; cap_awaddr = m_awaddr; cap_awprot = m_awprot;
      end
      if (rst_n && m_wvalid && m_wready) begin
         w_seen = 1; n_w++; cap_wdata = m_wdata; cap_wstrb = m_wstrb;
      end
      if (rst_n && m_arvalid && m_arready) begin
         ar_seen = 1; n_ar++; cap_araddr = m_araddr; cap_arprot = m_arprot;
      end
   end

   always @(posedge clk) begin
      #2;
      m_awready = ($urandom_range(0, 99) < aw_pct);
      m_wready  = ($urandom_range(0, 99) < w_pct);
      m_arready = ($urandom_range(0, 99) < ar_pct);
      if (m_bvalid) m_bvalid = 0;
      else if (aw_seen && w_seen) begin
         if (b_cnt >= resp_lat) begin m_bvalid = 1; aw_seen = 0; w_seen = 0; b_cnt = 0; end
         else b_cnt++;
      end else if (spur_b) begin m_bvalid = 1; spur_b = 0; end
      if (m_rvalid) begin m_rvalid = 0; m_rdata = 32'hBAD0_BAD0; end
      else if (ar_seen) begin
         if (r_cnt >= resp_lat) begin
            m_rvalid = 1; m_rdata = cap_araddr ^ RKEY; ar_seen = 0; r_cnt = 0;
         end else r_cnt++;
      end else if (spur_r) begin m_rvalid = 1; m_rdata = 32'hFEED_F00D; spur_r = 0; end
   end

   // ---------------- requester ----------------
   task automatic xfer(input logic [31:0] a, input logic [31:0] d, input logic [3:0] s,
                       input bit f, input bit hold, input int idle);
      logic [31:0] got;
      int guard;
      bit ok;
      @(posedge clk); #1;
      n_aw = 0; n_w = 0; n_ar = 0;
      req_valid = 1; req_addr = a; req_wdata = d; req_strb = s; req_fetch = f;
      guard = 0; ok = 0; got = '0;
      while (!ok && guard < 300) begin
         @(negedge clk);
         if (req_ready) begin ok = 1; got = req_rdata; end
         guard++;
      end
      chk("R6 R7 transfer completes", 64'(ok), 64'(1));
      if (s != 4'h0) begin
         chk("R3 one AW handshake", 64'(n_aw), 64'(1));
         chk("R4 one W handshake", 64'(n_w), 64'(1));
         chk("R3 slave awaddr", 64'(cap_awaddr), 64'(a));
         chk("R3 slave wdata", 64'(cap_wdata), 64'(d));
         chk("R3 slave wstrb", 64'(cap_wstrb), 64'(s));
         chk("R8 slave awprot", 64'(cap_awprot), 64'({f, 2'b00}));
         chk("R10 no AR on write", 64'(n_ar), 64'(0));
      end else begin
         chk("R5 one AR handshake", 64'(n_ar), 64'(1));
         chk("R2 no AW/W on read", 64'(n_aw + n_w), 64'(0));
         chk("R2 slave araddr", 64'(cap_araddr), 64'(a));
         chk("R8 slave arprot", 64'(cap_arprot), 64'({f, 2'b00}));
         chk("R7 R10 read data", 64'(got), 64'(a ^ RKEY));
      end
      if (!hold) begin
         @(posedge clk); #1;
         req_valid = 0;
         req_wdata = ~req_wdata;
         repeat (idle) @(posedge clk);
      end
   endtask

   bit done_all = 0;

   initial begin
      logic [3:0] legal [7];
      legal = '{4'hF, 4'hC, 4'h3, 4'h8, 4'h4, 4'h2, 4'h1};
      // R1: reset with a live-looking request on the inputs
      req_valid = 1; req_strb = 4'hF; req_addr = 32'h1000;
      repeat (5) @(posedge clk);
      #1;
      chk("R1 awvalid in reset", 64'(m_awvalid), 64'(0));
      chk("R1 req_ready in reset", 64'(req_ready), 64'(0));
      @(posedge clk); #1;
      rst_n = 1; req_valid = 0;
      repeat (2) @(posedge clk);

      // R3/R4: every legal strobe, varied ready densities
      for (int i = 0; i < 7; i++) begin
         aw_pct = (i % 3 == 0) ? 100 : 40; w_pct = (i % 2 == 0) ? 100 : 30;
         resp_lat = i % 3;
         xfer(32'h2000 + 32'(i * 4), 32'hA000_0000 + 32'(i), legal[i], 0, 0, i % 2);
      end
      // R4: address channel fast, data slow, and the reverse
      aw_pct = 100; w_pct = 15; xfer(32'h3000, 32'h1234_5678, 4'hF, 0, 0, 1);
      aw_pct = 15; w_pct = 100; xfer(32'h3004, 32'h8765_4321, 4'h3, 1, 0, 1);
      // R2/R5/R8: reads, fetch and data, with junk write data
      aw_pct = 100; w_pct = 100;
      ar_pct = 100; resp_lat = 0; xfer(32'h4000, 32'hFFFF_FFFF, 4'h0, 1, 0, 0);
      ar_pct = 25;  resp_lat = 2; xfer(32'h4010, 32'h0F0F_0F0F, 4'h0, 0, 0, 2);
      // R9: request kept high into the quiet cycle, then back-to-back
      ar_pct = 100; resp_lat = 0;
      xfer(32'h5000, 32'h5555_0001, 4'hF, 0, 1, 0);
      xfer(32'h5004, 32'h0, 4'h0, 1, 1, 0);
      xfer(32'h5008, 32'h5555_0002, 4'h1, 0, 0, 1);
      // R10: wrong-kind response while a transfer is outstanding
      resp_lat = 6;
      fork
         xfer(32'h6000, 32'h6666_0000, 4'hF, 0, 0, 1);
         begin repeat (2) @(posedge clk); spur_r = 1; end
      join
      fork
         xfer(32'h6100, 32'h0, 4'h0, 0, 0, 1);
         begin repeat (2) @(posedge clk); spur_b = 1; end
      join
      // mixed random traffic
      for (int k = 0; k < 40; k++) begin
         logic [3:0] s;
         aw_pct = $urandom_range(20, 100); w_pct = $urandom_range(20, 100);
         ar_pct = $urandom_range(20, 100); resp_lat = $urandom_range(0, 3);
         s = ($urandom_range(0, 2) == 0) ? 4'h0 : legal[$urandom_range(0, 6)];
         xfer({$urandom_range(0, 32'hFFFF), 2'b00}, $urandom, s, $urandom_range(0, 1),
              $urandom_range(0, 3) == 0, $urandom_range(0, 2));
      end
      @(posedge clk); #1; req_valid = 0;
      repeat (4) @(posedge clk);
      done_all = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done_all) begin
         nchk++; nfail++;
         $display("FAIL watchdog R6 R7 actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

endmodule